// File: doc/BRIEF.md
# Reversible Four-Wire Full Adder

This block adds three bits (a, b and a carry-in) using only reversible gates: controlled-NOT, doubly controlled NOT and controlled swap. A fourth input, the preset line, sits beside the three data bits. Two extra outputs, called garbage lines, sit beside the carry-out and the sum. Together these make the complete 4-bit to 4-bit map one-to-one. The gates are joined line to line. No net drives more than one gate input, and there is no feedback.

A parameter picks one of two gate-level netlists. The first uses two controlled-NOTs and two doubly controlled NOTs. The second uses three controlled-NOTs and a single controlled swap. An inverse netlist runs the same gates in reverse order, and each gate undoes itself. It takes the forward word and returns the original inputs. That result is brought out on the recovery ports so that a user can confirm the map is reversible.

Following the house register style, the forward word and the recovered word are both captured in output flops on the same clock edge. A synchronous active-high reset clears them.

Top module: `rev_full_adder`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs (`co`, `s`, `g1`, `g2`, `rec_a`, `rec_b`, `rec_ci`, `rec_preset`) are 0 after that edge.
- R2: Each output reflects the inputs sampled at the previous rising edge (latency of exactly one cycle).
- R3: With `preset` = 0, `co` is the carry and `s` is the sum bit of a + b + ci, in both variants.
- R4: For each variant, the 16 input words {a,b,ci,preset} give 16 distinct output words {co,s,g1,g2}.
- R5: With VARIANT = 0 (four gates of the controlled-NOT family): g1 = a, g2 = a XOR b, co = preset XOR majority(a,b,ci).
- R6: With VARIANT = 1 (three controlled-NOTs and one controlled swap): g1 = a XOR b. When a XOR b = 1, co = preset XOR ci and g2 = a. Otherwise co = a and g2 = preset XOR ci.
- R7: The recovery outputs {rec_a,rec_b,rec_ci,rec_preset} equal the inputs {a,b,ci,preset} of the same sample, in both variants.
- R8: `s` = a XOR b XOR ci whatever the value of `preset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 1 | First addend bit |
| b | input | 1 | Second addend bit |
| ci | input | 1 | Carry-in bit |
| preset | input | 1 | Constant line; 0 for normal addition |
| co | output | 1 | Carry-out (registered) |
| s | output | 1 | Sum (registered) |
| g1 | output | 1 | First garbage line (registered) |
| g2 | output | 1 | Second garbage line (registered) |
| rec_a | output | 1 | Recovered a from the inverse netlist |
| rec_b | output | 1 | Recovered b |
| rec_ci | output | 1 | Recovered carry-in |
| rec_preset | output | 1 | Recovered preset |

## Verification
The forward addition and the inverse recovery land in the same output register on the same edge. Every applied word therefore checks the sum and carry and the round trip together, and each is judged against its own bench model. Both variants are swept across all sixteen words, including the preset-high half. The collected output words are then compared pairwise for distinctness. After that, seeded random words mixed with a mid-stream reset show that both results keep appearing exactly one cycle after their inputs.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int WIRES       = 4;
  localparam int VAR_FEYNMAN = 0;
  localparam int VAR_MIXED   = 1;

  // input word order  {a, b, ci, preset}
  // output word order {co, s, g1, g2}
  localparam int IDX_HI  = 3;
  localparam int IDX_MH  = 2;
  localparam int IDX_ML  = 1;
  localparam int IDX_LO  = 0;

  typedef logic [WIRES-1:0] lines_t;
endpackage

// File: rtl/rev_cnot.sv
module rev_cnot (
  input  logic ctl_i,
  input  logic tgt_i,
  output logic ctl_o,
  output logic tgt_o
);
  assign ctl_o = ctl_i;
  assign tgt_o = tgt_i ^ ctl_i;
endmodule

// File: rtl/rev_toffoli.sv
module rev_toffoli (
  input  logic c1_i,
  input  logic c2_i,
  input  logic tgt_i,
  output logic c1_o,
  output logic c2_o,
  output logic tgt_o
);
  assign c1_o  = c1_i;
  assign c2_o  = c2_i;
  assign tgt_o = tgt_i ^ (c1_i & c2_i);
endmodule

// File: rtl/rev_fredkin.sv
module rev_fredkin (
  input  logic ctl_i,
  input  logic x_i,
  input  logic y_i,
  output logic ctl_o,
  output logic x_o,
  output logic y_o
);
  // controlled swap: lines exchange when ctl_i is high
  assign ctl_o = ctl_i;
  assign x_o   = ctl_i ? y_i : x_i;
  assign y_o   = ctl_i ? x_i : y_i;
endmodule

// File: rtl/rev_adder_fwd.sv
module rev_adder_fwd
  import rfa_pkg::*;
#(
  parameter int VARIANT = VAR_FEYNMAN
) (
  input  lines_t in_w,   // {a, b, ci, preset}
  output lines_t out_w   // {co, s, g1, g2}
);
  logic la, lb, lc, lp;
  assign la = in_w[IDX_HI];
  assign lb = in_w[IDX_MH];
  assign lc = in_w[IDX_ML];
  assign lp = in_w[IDX_LO];

  generate
    if (VARIANT == VAR_FEYNMAN) begin : g_feyn
      logic a1, b1, p1, a2, b2, b3, c3, p3, b4, c4;
      // preset ^= a&b
      rev_toffoli u_t1 (.c1_i(la), .c2_i(lb), .tgt_i(lp),
                        .c1_o(a1), .c2_o(b1), .tgt_o(p1));
      // b = a ^ b
      rev_cnot    u_c1 (.ctl_i(a1), .tgt_i(b1), .ctl_o(a2), .tgt_o(b2));
      // preset ^= (a^b)&ci  -> preset ^ majority
      rev_toffoli u_t2 (.c1_i(b2), .c2_i(lc), .tgt_i(p1),
                        .c1_o(b3), .c2_o(c3), .tgt_o(p3));
      // ci = a ^ b ^ ci
      rev_cnot    u_c2 (.ctl_i(b3), .tgt_i(c3), .ctl_o(b4), .tgt_o(c4));
      assign out_w = {p3, c4, a2, b4};
    end else begin : g_mixed
      logic c1, p1, a2, b2, b3, a3, p3, b4, c4;
      // preset ^= ci
      rev_cnot    u_c1 (.ctl_i(lc), .tgt_i(lp), .ctl_o(c1), .tgt_o(p1));
      // b = a ^ b
      rev_cnot    u_c2 (.ctl_i(la), .tgt_i(lb), .ctl_o(a2), .tgt_o(b2));
      // swap a and preset^ci when a != b: a line becomes the carry
      rev_fredkin u_f1 (.ctl_i(b2), .x_i(a2), .y_i(p1),
                        .ctl_o(b3), .x_o(a3), .y_o(p3));
      // ci = a ^ b ^ ci
      rev_cnot    u_c3 (.ctl_i(b3), .tgt_i(c1), .ctl_o(b4), .tgt_o(c4));
      assign out_w = {a3, c4, b4, p3};
    end
  endgenerate
endmodule

// File: rtl/rev_adder_inv.sv
module rev_adder_inv
  import rfa_pkg::*;
#(
  parameter int VARIANT = VAR_FEYNMAN
) (
  input  lines_t in_w,   // {co, s, g1, g2}
  output lines_t out_w   // {a, b, ci, preset}
);
  logic lco, ls, lg1, lg2;
  assign lco = in_w[IDX_HI];
  assign ls  = in_w[IDX_MH];
  assign lg1 = in_w[IDX_ML];
  assign lg2 = in_w[IDX_LO];

  generate
    if (VARIANT == VAR_FEYNMAN) begin : g_feyn
      // line map: a=g1, b=g2, ci=s, preset=co; gates in reverse order
      logic b1, c1, b2, c2, p2, a3, b3, a4, b4, p4;
      rev_cnot    u_c2 (.ctl_i(lg2), .tgt_i(ls), .ctl_o(b1), .tgt_o(c1));
      rev_toffoli u_t2 (.c1_i(b1), .c2_i(c1), .tgt_i(lco),
                        .c1_o(b2), .c2_o(c2), .tgt_o(p2));
      rev_cnot    u_c1 (.ctl_i(lg1), .tgt_i(b2), .ctl_o(a3), .tgt_o(b3));
      rev_toffoli u_t1 (.c1_i(a3), .c2_i(b3), .tgt_i(p2),
                        .c1_o(a4), .c2_o(b4), .tgt_o(p4));
      assign out_w = {a4, b4, c2, p4};
    end else begin : g_mixed
      // line map: a=co, b=g1, ci=s, preset=g2; gates in reverse order
      logic b1, c1, b2, a2, p2, a3, b3, c4, p4;
      rev_cnot    u_c3 (.ctl_i(lg1), .tgt_i(ls), .ctl_o(b1), .tgt_o(c1));
      rev_fredkin u_f1 (.ctl_i(b1), .x_i(lco), .y_i(lg2),
                        .ctl_o(b2), .x_o(a2), .y_o(p2));
      rev_cnot    u_c2 (.ctl_i(a2), .tgt_i(b2), .ctl_o(a3), .tgt_o(b3));
      rev_cnot    u_c1 (.ctl_i(c1), .tgt_i(p2), .ctl_o(c4), .tgt_o(p4));
      assign out_w = {a3, b3, c4, p4};
    end
  endgenerate
endmodule

// File: rtl/rev_full_adder.sv
module rev_full_adder
  import rfa_pkg::*;
#(
  parameter int VARIANT = VAR_FEYNMAN
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic ci,
  input  logic preset,
  output logic co,
  output logic s,
  output logic g1,
  output logic g2,
  output logic rec_a,
  output logic rec_b,
  output logic rec_ci,
  output logic rec_preset
);
  lines_t in_word, fwd_word, inv_word, fwd_q, inv_q;

  assign in_word = {a, b, ci, preset};

  rev_adder_fwd #(.VARIANT(VARIANT)) u_fwd (.in_w(in_word), .out_w(fwd_word));
  rev_adder_inv #(.VARIANT(VARIANT)) u_inv (.in_w(fwd_word), .out_w(inv_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q <= '0;
      inv_q <= '0;
    end else begin
      fwd_q <= fwd_word;
      inv_q <= inv_word;
    end
  end

  assign {co, s, g1, g2} = fwd_q;
  assign {rec_a, rec_b, rec_ci, rec_preset} = inv_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (fwd_q == '0 && inv_q == '0)); // R1

  AST_ADD_P0: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(preset)) |->
      ({co, s} == ($past(a) + $past(b) + $past(ci)))); // R3

  AST_SUM_ANY_PRESET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (s == ($past(a) ^ $past(b) ^ $past(ci)))); // R8

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ({rec_a, rec_b, rec_ci, rec_preset} ==
       {$past(a), $past(b), $past(ci), $past(preset)})); // R7

  generate
    if (VARIANT == VAR_FEYNMAN) begin : g_chk_feyn
      AST_FEYN_GARBAGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (g1 == $past(a) && g2 == ($past(a) ^ $past(b)))); // R5
    end else begin : g_chk_mixed
      AST_MIXED_GARBAGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (g1 == ($past(a) ^ $past(b)))); // R6
    end
  endgenerate
endmodule

// File: tb/rev_full_adder_tb.sv
module rev_full_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 300;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0, b = 1'b0, ci = 1'b0, preset = 1'b0;
  logic co0, s0, g10, g20, ra0, rb0, rc0, rp0;
  logic co1, s1, g11, g21, ra1, rb1, rc1, rp1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [3:0] seen [2][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_full_adder #(.VARIANT(0)) u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .ci(ci), .preset(preset),
    .co(co0), .s(s0), .g1(g10), .g2(g20),
    .rec_a(ra0), .rec_b(rb0), .rec_ci(rc0), .rec_preset(rp0));

  rev_full_adder #(.VARIANT(1)) u_dut_mixed (
    .clk(clk), .rst(rst), .a(a), .b(b), .ci(ci), .preset(preset),
    .co(co1), .s(s1), .g1(g11), .g2(g21),
    .rec_a(ra1), .rec_b(rb1), .rec_ci(rc1), .rec_preset(rp1));

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // expected {co, s, g1, g2} from the requirements
  function automatic logic [3:0] model(input int v, input logic [3:0] w);
    logic xa, xb, xc, xp, xab;
    {xa, xb, xc, xp} = w;
    xab = xa ^ xb;
    if (v == 0) return {xp ^ maj3(xa, xb, xc), xab ^ xc, xa, xab};
    return {xab ? (xp ^ xc) : xa, xab ^ xc, xab, xab ? xa : (xp ^ xc)};
  endfunction

  function automatic logic [3:0] out_of(input int v);
    return (v == 0) ? {co0, s0, g10, g20} : {co1, s1, g11, g21};
  endfunction

  function automatic logic [3:0] rec_of(input int v);
    return (v == 0) ? {ra0, rb0, rc0, rp0} : {ra1, rb1, rc1, rp1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // drive at negedge, judge a quarter period after the next rising edge
  task automatic apply_and_check(input logic [3:0] w, input bit record);
    @(negedge clk);
    {a, b, ci, preset} = w;
    @(posedge clk);
    #(CLK_PERIOD/4);
    for (int v = 0; v < 2; v++) begin
      logic [3:0] got, exp;
      got = out_of(v);
      exp = model(v, w);
      if (record) seen[v][w] = got;
      // R2 R5 R6: whole word one cycle later
      check(got == exp, (v == 0) ? "R5 R2" : "R6 R2", {4'h0, got}, {4'h0, exp});
      // R3: plain addition when preset low
      if (!w[0])
        check(got[3:2] == (2'(w[3]) + 2'(w[2]) + 2'(w[1])), "R3",
              {6'h0, got[3:2]}, {6'h0, 2'(w[3]) + 2'(w[2]) + 2'(w[1])});
      // R8: sum independent of preset
      check(got[2] == ^w[3:1], "R8", {7'h0, got[2]}, {7'h0, ^w[3:1]});
      // R7: round trip
      check(rec_of(v) == w, "R7", {4'h0, rec_of(v)}, {4'h0, w});
    end
  endtask

  task automatic check_reset_zero();
    for (int v = 0; v < 2; v++)
      check({out_of(v), rec_of(v)} == 8'h00, "R1", {out_of(v), rec_of(v)}, 8'h00);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    // reset held with nonzero inputs
    {a, b, ci, preset} = 4'hF;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_reset_zero();
    @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep of all 16 words
    for (int w = 0; w < 16; w++) apply_and_check(4'(w), 1'b1);

    // R4: pairwise distinctness per variant
    for (int v = 0; v < 2; v++) begin
      int dup;
      dup = 0;
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          if (seen[v][i] == seen[v][j]) dup++;
      check(dup == 0, "R4", 8'(dup), 8'h00);
    end

    // directed corners: all ones, carry ripple patterns
    apply_and_check(4'b1110, 1'b0);
    apply_and_check(4'b1111, 1'b0);
    apply_and_check(4'b0000, 1'b0);
    apply_and_check(4'b1010, 1'b0);

    // mid-stream reset
    @(negedge clk);
    {a, b, ci, preset} = 4'b1101;
    rst = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_reset_zero();
    @(negedge clk);
    rst = 1'b0;

    // seeded random stream
    for (int n = 0; n < N_RANDOM; n++) apply_and_check(4'($urandom() & 32'hF), 1'b0);

    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
    end
  end
endmodule